// File: doc/BRIEF.md
# Atomic Read-Modify-Write Engine

This block takes one memory read-modify-write request at a time from a processor-side port and performs it on a shared memory bus. It reads the target location, computes the new value, and writes the result back. When the operation is atomic, a lock is held from the start of the read to the end of the write, so no other bus master can reach the location between the two accesses. The supported operations are compare-and-swap, exchange, exchange-add, arithmetic updates (add, add with carry, subtract, subtract with borrow, increment, decrement, negate) and logical updates (and, or, xor, not, bit test with complement, reset or set). Operands are 8, 16, 32 or 64 bits wide.

The lock takes one of two forms. If the target carries the write-back cached attribute and every byte of the operand falls in one cache line, an internal line lock is asserted. Otherwise the external bus lock is asserted, and this includes misaligned operands that cross a line boundary. A request the engine cannot execute is answered at once with an undefined-opcode error and produces no bus traffic. A read that returns an error ends the sequence: the lock is released and no write is issued.

Top module: `atomic_rmw_engine`

## Requirements
- R1: For compare-and-swap (op code 6), the low 8<<size bits of the accumulator are compared with the old memory value. On a match, the source is written and rspOk is 1. On a mismatch, rspAcc returns the old value zero-extended and rspOk is 0. Higher accumulator bits are ignored.
- R2: Every legal request produces exactly one read (memWe=0) and then exactly one write (memWe=1). A failed compare-and-swap writes the old value back unchanged.
- R3: busLock and lineLock are only high while memReq is high. An active lock stays at the same level from the read cycle through the acknowledge of the write.
- R4: A read acknowledged with memErr causes no write. The lock drops in the next cycle, and the response carries rspBusErr=1.
- R5: An op code above 16, or reqMemDst=0, gives a response with rspUndef=1 and no memory access.
- R6: Exchange (op code 16) is locked even when reqLock is 0.
- R7: A locked operation with reqCached=1 whose first and last bytes share a line index (LINE_BYTES=64) asserts only lineLock. Any other locked operation asserts only busLock, and this includes misaligned operands that cross a line.
- R8: The written value follows the op code (0 add, 1 add+carry, 2 and, 3 bit complement, 4 bit reset, 5 bit set, 7 decrement, 8 increment, 9 negate, 10 not, 11 or, 12 sub-borrow, 13 sub, 14 xor, 15 exchange-add, 16 exchange). It is masked to the size code (0:8, 1:16, 2:32, 3:64 bits). The bit index is the source modulo the width. rspOld returns the masked old value.
- R9: A legal request with reqLock=0 and an op code other than 16 asserts neither lock.
- R10: reqReady is high only when the engine is idle and neither bus nor response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Engine idle, request accepted |
| reqOp | input | 5 | Operation code |
| reqLock | input | 1 | Atomic execution requested |
| reqMemDst | input | 1 | Destination is memory |
| reqCached | input | 1 | Target is write-back cached |
| reqSize | input | 2 | Operand size code |
| reqAddr | input | ADDR_W | Byte address |
| reqAcc | input | 64 | Accumulator (compare value) |
| reqSrc | input | 64 | Source operand |
| reqCarry | input | 1 | Carry/borrow in |
| rspValid | output | 1 | Response pulse |
| rspOld | output | 64 | Old memory value |
| rspAcc | output | 64 | Updated accumulator |
| rspOk | output | 1 | Compare-and-swap succeeded |
| rspUndef | output | 1 | Undefined-opcode error |
| rspBusErr | output | 1 | Read error, sequence aborted |
| memReq | output | 1 | Bus access active |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Bus address |
| memSize | output | 2 | Bus size code |
| memWdata | output | 64 | Write data |
| memAck | input | 1 | Bus response valid |
| memRdata | input | 64 | Read data |
| memErr | input | 1 | Read error with memAck |
| busLock | output | 1 | External bus lock |
| lineLock | output | 1 | Internal cache-line lock |

## Verification
Two situations are hard to reach from the ports. The first is the gap between a read acknowledge and the following write. Here the lock must not flicker, and a failed compare must still write. The second is an error on the read, which must leave no write behind. The bench memory model answers after random delays, records the lock levels it sees on every acknowledge, and counts any cycle in which a lock is high without a bus access. Directed cases then force a compare mismatch with differing upper accumulator bits, inject a read error, and place operands on either side of a line boundary, with the cached attribute both set and clear.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_AND = 5'd2,  OP_BTC = 5'd3,
    OP_BTR = 5'd4,  OP_BTS = 5'd5,  OP_CAS = 5'd6,  OP_DEC = 5'd7,
    OP_INC = 5'd8,  OP_NEG = 5'd9,  OP_NOT = 5'd10, OP_OR  = 5'd11,
    OP_SBB = 5'd12, OP_SUB = 5'd13, OP_XOR = 5'd14, OP_XADD = 5'd15,
    OP_XCHG = 5'd16
  } rmw_op_e;

  localparam logic [4:0] LAST_LEGAL_OP = 5'd16;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RSP} rmw_state_e;

  typedef struct packed {
    logic capReq;
    logic capRead;
  } rmw_strobe_t;

  function automatic logic [63:0] sizeMask(input logic [1:0] size);
    case (size)
      2'd0:    sizeMask = 64'h0000_0000_0000_00FF;
      2'd1:    sizeMask = 64'h0000_0000_0000_FFFF;
      2'd2:    sizeMask = 64'h0000_0000_FFFF_FFFF;
      default: sizeMask = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/atomic_rmw_dp.sv
module atomic_rmw_dp
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  rmw_strobe_t       strobe,
  input  logic [4:0]        reqOp,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqAcc,
  input  logic [63:0]       reqSrc,
  input  logic              reqCarry,
  input  logic [63:0]       memRdata,
  output logic              fitsLine,
  output logic [ADDR_W-1:0] addrQ,
  output logic [1:0]        sizeQ,
  output logic [63:0]       oldQ,
  output logic [63:0]       newVal,
  output logic [63:0]       accOut,
  output logic              isCas,
  output logic              casMatch
);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);

  logic [4:0]  opQ;
  logic [63:0] accQ, srcQ;
  logic        carryQ;

  // line-fit check on the incoming request, one extra bit so no wrap
  logic [ADDR_W:0] firstByte, lastByte;
  always_comb begin
    firstByte = {1'b0, reqAddr};
    lastByte  = firstByte + ((ADDR_W+1)'(1) << reqSize) - (ADDR_W+1)'(1);
    fitsLine  = (firstByte >> LINE_SHIFT) == (lastByte >> LINE_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= '0; sizeQ <= '0; addrQ <= '0; accQ <= '0;
      srcQ <= '0; carryQ <= 1'b0; oldQ <= '0;
    end else begin
      if (strobe.capReq) begin
        opQ <= reqOp; sizeQ <= reqSize; addrQ <= reqAddr;
        accQ <= reqAcc; srcQ <= reqSrc; carryQ <= reqCarry;
      end
      if (strobe.capRead) oldQ <= memRdata & sizeMask(sizeQ);
    end
  end

  logic [63:0] mask, bitSel, raw;
  logic [5:0]  bitIdx;
  always_comb begin
    mask     = sizeMask(sizeQ);
    bitIdx   = srcQ[5:0] & 6'((8 << sizeQ) - 1);
    bitSel   = 64'd1 << bitIdx;
    isCas    = opQ == OP_CAS;
    casMatch = (accQ & mask) == oldQ;
    case (opQ)
      OP_ADD, OP_XADD: raw = oldQ + srcQ;
      OP_ADC:  raw = oldQ + srcQ + {63'd0, carryQ};
      OP_AND:  raw = oldQ & srcQ;
      OP_BTC:  raw = oldQ ^ bitSel;
      OP_BTR:  raw = oldQ & ~bitSel;
      OP_BTS:  raw = oldQ | bitSel;
      OP_CAS:  raw = casMatch ? srcQ : oldQ;
      OP_DEC:  raw = oldQ - 64'd1;
      OP_INC:  raw = oldQ + 64'd1;
      OP_NEG:  raw = 64'd0 - oldQ;
      OP_NOT:  raw = ~oldQ;
      OP_OR:   raw = oldQ | srcQ;
      OP_SBB:  raw = oldQ - srcQ - {63'd0, carryQ};
      OP_SUB:  raw = oldQ - srcQ;
      OP_XOR:  raw = oldQ ^ srcQ;
      default: raw = srcQ;
    endcase
    newVal = raw & mask;
    accOut = (isCas && !casMatch) ? oldQ : accQ;
  end

  // R1: a matching compare writes the masked source
  p_cas_match_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    (isCas && casMatch) |-> newVal == (srcQ & mask));

endmodule

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl
  import atomic_rmw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [4:0]  reqOp,
  input  logic        reqLock,
  input  logic        reqMemDst,
  input  logic        reqCached,
  input  logic        fitsLine,
  input  logic        memAck,
  input  logic        memErr,
  output logic        reqReady,
  output logic        memReq,
  output logic        memWe,
  output logic        busLock,
  output logic        lineLock,
  output logic        rspValid,
  output logic        rspUndef,
  output logic        rspBusErr,
  output rmw_strobe_t strobe
);
  rmw_state_e state;
  logic lockQ, lineQ, xchgQ, undefQ, busErrQ;
  logic legal, needLock;

  always_comb begin
    legal    = reqMemDst && (reqOp <= LAST_LEGAL_OP);
    needLock = reqLock || (reqOp == OP_XCHG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; lockQ <= 1'b0; lineQ <= 1'b0; xchgQ <= 1'b0;
      undefQ <= 1'b0; busErrQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          busErrQ <= 1'b0;
          undefQ  <= !legal;
          lockQ   <= legal && needLock;
          lineQ   <= reqCached && fitsLine;
          xchgQ   <= reqOp == OP_XCHG;
          state   <= legal ? ST_RD : ST_RSP;
        end
        ST_RD: if (memAck) begin
          if (memErr) begin
            busErrQ <= 1'b1;
            state   <= ST_RSP;
          end else begin
            state <= ST_WR;
          end
        end
        ST_WR:  if (memAck) state <= ST_RSP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic lockOn;
  always_comb begin
    reqReady       = state == ST_IDLE;
    memReq         = (state == ST_RD) || (state == ST_WR);
    memWe          = state == ST_WR;
    lockOn         = memReq && lockQ;
    busLock        = lockOn && !lineQ;
    lineLock       = lockOn && lineQ;
    rspValid       = state == ST_RSP;
    rspUndef       = rspValid && undefQ;
    rspBusErr      = rspValid && busErrQ;
    strobe.capReq  = reqReady && reqValid;
    strobe.capRead = (state == ST_RD) && memAck;
  end

  // R2: a clean read is always followed by a write
  p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && !memErr) |=> (memReq && memWe));
  // R3: lock level does not change between read and write
  p_lock_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((busLock || lineLock) && !memWe && memAck && !memErr) |=> $stable({busLock, lineLock}));
  // R4: read error aborts and releases the lock
  p_err_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck && memErr) |=> (!memReq && !busLock && !lineLock && rspBusErr));
  // R5: undefined requests never touched the bus
  p_undef_no_bus_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspUndef |-> !$past(memReq));
  // R6: exchange is always locked
  p_xchg_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && xchgQ) |-> (busLock || lineLock));
  // R7: never both lock forms at once
  p_one_lock_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(busLock && lineLock));
  // R10: ready only when fully quiet
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReq && !rspValid));

endmodule

// File: rtl/atomic_rmw_engine.sv
module atomic_rmw_engine
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [4:0]        reqOp,
  input  logic              reqLock,
  input  logic              reqMemDst,
  input  logic              reqCached,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [63:0]       reqAcc,
  input  logic [63:0]       reqSrc,
  input  logic              reqCarry,
  output logic              rspValid,
  output logic [63:0]       rspOld,
  output logic [63:0]       rspAcc,
  output logic              rspOk,
  output logic              rspUndef,
  output logic              rspBusErr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic [63:0]       memRdata,
  input  logic              memErr,
  output logic              busLock,
  output logic              lineLock
);
  rmw_strobe_t strobe;
  logic fitsLine, isCas, casMatch;
  logic [63:0] oldQ, newVal, accOut;

  atomic_rmw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqLock(reqLock), .reqMemDst(reqMemDst), .reqCached(reqCached),
    .fitsLine(fitsLine), .memAck(memAck), .memErr(memErr),
    .reqReady(reqReady), .memReq(memReq), .memWe(memWe),
    .busLock(busLock), .lineLock(lineLock), .rspValid(rspValid),
    .rspUndef(rspUndef), .rspBusErr(rspBusErr), .strobe(strobe)
  );

  atomic_rmw_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqOp(reqOp),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqAcc(reqAcc),
    .reqSrc(reqSrc), .reqCarry(reqCarry), .memRdata(memRdata),
    .fitsLine(fitsLine), .addrQ(memAddr), .sizeQ(memSize), .oldQ(oldQ),
    .newVal(newVal), .accOut(accOut), .isCas(isCas), .casMatch(casMatch)
  );

  assign memWdata = newVal;
  assign rspOld   = oldQ;
  assign rspAcc   = accOut;
  assign rspOk    = rspValid && !rspUndef && !rspBusErr && isCas && casMatch;

  // R2: a failing compare writes the old value back
  p_cas_fail_rewrite_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && isCas && !casMatch) |-> memWdata == rspOld);

endmodule

// File: tb/test_atomic_rmw_engine.sv
`timescale 1ns/1ps
module test_atomic_rmw_engine;
  localparam int AW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic reqValid = 0, reqLock = 0, reqMemDst = 0, reqCached = 0, reqCarry = 0;
  logic [4:0] reqOp = 0; logic [1:0] reqSize = 0; logic [AW-1:0] reqAddr = 0;
  logic [63:0] reqAcc = 0, reqSrc = 0;
  logic reqReady, rspValid, rspOk, rspUndef, rspBusErr, memReq, memWe, busLock, lineLock;
  logic [63:0] rspOld, rspAcc, memWdata;
  logic [AW-1:0] memAddr; logic [1:0] memSize;
  logic memAck = 0, memErr = 0; logic [63:0] memRdata = 0;

  atomic_rmw_engine i_atomic_rmw_engine (.*);

  int checks = 0, failures = 0;
  logic [63:0] mem [16];
  int reads = 0, writes = 0, dly = 0, strayLock = 0, cycles = 0;
  logic injectErr = 0;
  logic [1:0] rdLk = 0, wrLk = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random latency, records lock levels at each acknowledge
  always @(negedge clk) begin
    cycles++;
    if ((busLock || lineLock) && !memReq) strayLock++;
    if (memAck) begin
      memAck = 0; memErr = 0;
    end else if (memReq) begin
      if (dly == 0) begin
        memAck = 1;
        if (memWe) begin
          writes++; mem[memAddr[3:0]] = memWdata; wrLk = {busLock, lineLock};
        end else begin
          reads++; memRdata = mem[memAddr[3:0]]; memErr = injectErr;
          rdLk = {busLock, lineLock};
        end
        dly = int'($urandom % 3);
      end else dly--;
    end
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [63:0] msk(input logic [1:0] s);
    return (s == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  function automatic logic [63:0] refNew(input logic [4:0] op, input logic [1:0] s,
      input logic [63:0] o, input logic [63:0] src, input logic [63:0] acc, input logic c);
    logic [63:0] b, r;
    b = 64'd1 << (src % (64'd8 << s));
    case (op)
      0, 15: r = o + src;     1: r = o + src + 64'(c);
      2: r = o & src;         3: r = o ^ b;
      4: r = o & ~b;          5: r = o | b;
      6: r = ((acc & msk(s)) == o) ? src : o;
      7: r = o - 1;           8: r = o + 1;
      9: r = -o;              10: r = ~o;
      11: r = o | src;        12: r = o - src - 64'(c);
      13: r = o - src;        14: r = o ^ src;
      default: r = src;
    endcase
    return r & msk(s);
  endfunction

  task automatic run(input logic [4:0] op, input logic [1:0] s, input logic [AW-1:0] a,
      input logic lk, input logic dst, input logic cch, input logic [63:0] acc,
      input logic [63:0] src, input logic c, input logic err);
    logic [63:0] o, nv; logic legal, lockOn, fits; logic [1:0] expLk;
    int r0, w0, waitN;
    o = mem[a[3:0]] & msk(s);
    nv = refNew(op, s, o, src, acc, c);
    legal = dst && op <= 16;
    lockOn = legal && (lk || op == 16);
    fits = ({1'b0, a} >> 6) == (({1'b0, a} + 17'(1 << s) - 17'd1) >> 6);
    expLk = !lockOn ? 2'b00 : (cch && fits) ? 2'b01 : 2'b10;
    r0 = reads; w0 = writes; injectErr = err; rdLk = 2'b11; wrLk = 2'b11;
    @(negedge clk);
    chk(reqReady, "R10 ready when idle", 64'(reqReady), 64'd1);
    reqValid = 1; reqOp = op; reqSize = s; reqAddr = a; reqLock = lk;
    reqMemDst = dst; reqCached = cch; reqAcc = acc; reqSrc = src; reqCarry = c;
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R10 busy after accept", 64'(reqReady), 64'd0);
    waitN = 0;
    while (!rspValid && waitN < 100) begin @(negedge clk); waitN++; end
    injectErr = 0;
    if (!legal) begin
      chk(rspUndef && reads == r0 && writes == w0, "R5 undefined, no access",
          64'(reads - r0 + writes - w0), 64'd0);
    end else if (err) begin
      chk(rspBusErr && reads == r0 + 1 && writes == w0, "R4 error aborts write",
          64'(writes - w0), 64'd0);
      chk(!busLock && !lineLock, "R4 lock released", {62'd0, busLock, lineLock}, 64'd0);
    end else begin
      chk(reads == r0 + 1 && writes == w0 + 1, "R2 one read one write",
          64'(reads - r0) * 16 + 64'(writes - w0), 64'h11);
      chk(rspOld == o, "R8 old value", rspOld, o);
      chk(mem[a[3:0]] == nv, (op == 6) ? "R1/R2 cas write" : "R8 result",
          mem[a[3:0]], nv);
      chk(rdLk == expLk && wrLk == expLk,
          (op == 16 && !lk) ? "R6 xchg lock" : (lockOn ? "R7 lock kind" : "R9 no lock"),
          {60'd0, rdLk, wrLk}, {60'd0, expLk, expLk});
      if (op == 6) begin
        chk(rspOk == ((acc & msk(s)) == o), "R1 cas flag", 64'(rspOk), 64'((acc & msk(s)) == o));
        chk(rspAcc == (((acc & msk(s)) == o) ? acc : o), "R1 cas accumulator", rspAcc,
            ((acc & msk(s)) == o) ? acc : o);
      end
    end
    @(negedge clk);
    chk(reqReady, "R10 idle after response", 64'(reqReady), 64'd1);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    chk(reqReady && !memReq && !busLock && !lineLock && !rspValid, "R3 reset state",
        {59'd0, reqReady, memReq, busLock, lineLock, rspValid}, 64'h10);
    rstN = 1;
    // directed corner cases
    mem[4] = 64'h1111_2222_3333_4444;
    run(6, 2, 16'h0004, 1, 1, 0, 64'hDEAD_BEEF_3333_4444, 64'h55, 0, 0); // R1 match, upper acc differ
    run(6, 2, 16'h0004, 1, 1, 0, 64'h0000_0000_0000_0001, 64'h99, 0, 0); // R1 mismatch, R2 rewrite
    run(16, 3, 16'h0008, 0, 1, 0, 0, 64'hABCD, 0, 0);                  // R6 unlocked exchange
    run(17, 0, 16'h0002, 1, 1, 0, 0, 0, 0, 0);                         // R5 illegal op
    run(0, 0, 16'h0002, 1, 0, 0, 0, 1, 0, 0);                          // R5 register destination
    run(8, 1, 16'h0003, 1, 1, 0, 0, 0, 0, 1);                          // R4 read error
    run(0, 2, 16'h0030, 1, 1, 1, 0, 7, 0, 0);                          // R7 cached in line
    run(0, 2, 16'h003E, 1, 1, 1, 0, 7, 0, 0);                          // R7 misaligned crossing
    run(13, 3, 16'h0041, 1, 1, 0, 0, 5, 0, 0);                         // R7 uncached
    run(0, 1, 16'h0005, 0, 1, 1, 0, 3, 0, 0);                          // R9 unlocked add
    run(3, 0, 16'h0006, 1, 1, 0, 0, 64'd13, 0, 0);                     // R8 bit index wraps
    // constrained random
    for (int i = 0; i < 120; i++) begin
      logic [63:0] acc;
      acc = ($urandom % 2) ? mem[i % 16] : {$urandom, $urandom};
      run(5'($urandom % 17), 2'($urandom), 16'($urandom), 1'($urandom), 1'b1, 1'($urandom),
          acc, {$urandom, $urandom}, 1'($urandom), 1'b0);
    end
    chk(strayLock == 0, "R3 lock only during access", 64'(strayLock), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule